// File: doc/BRIEF.md
# Doorbell Mailbox Console Endpoint

This block is the local end of a character console that runs over four registers shared with a host. Two of them are 32-bit mailboxes, one for each direction. The other two are doorbells: the host rings the inbound one, and the block rings the outbound one. When the local side sends a character, the block waits for the outgoing mailbox to read zero. It then writes the character with a valid marker in the top bit and rings the outbound doorbell with the data code. The host empties that mailbox once it has taken the character.

The host rings the inbound doorbell with a message code. The block decodes the code and acknowledges every message. A ping is echoed back. A connect message resets the receive path. A data message moves the low byte of the incoming mailbox into a ring buffer, and the local consumer drains that buffer through a byte-wide read port.

Flow control needs no extra signalling. The block clears the incoming mailbox only while the ring still has headroom. The host must not post another character until the mailbox reads zero, so a mailbox left nonzero stalls the sender until the consumer has freed enough entries. A local request can also close the session: it sends a disconnect code and waits for a new connect.

Top module: `mcon_endpoint`

## Requirements
- R1: After reset, `connected` is 0, `rd_avail` is 0, `tx_ready` is 1, both mailboxes read 0 and `out_db_valid` is 0.
- R2: A local character is written to the outgoing mailbox as bit 31 set plus the character in bits 7:0, and only while that mailbox reads zero. In the same cycle the outbound doorbell carries code 0x5. The mailbox then holds its value until `host_tx_clr` is pulsed.
- R3: After character 0x0A is sent, the block sends character 0x0D without being asked, once the host has cleared the mailbox. `tx_ready` stays low until the 0x0D has gone out.
- R4: A doorbell code written by the host is handled on the next clock edge, and `in_db_ack` pulses for one cycle. Any code other than 0x1, 0x2 and 0x5 is acknowledged and changes nothing else: no outbound doorbell, and the ring and mailboxes are unchanged.
- R5: Code 0x1 (ping) is answered by an outbound doorbell with code 0x1.
- R6: Code 0x2 (connect) empties the ring, clears the incoming mailbox and sets `connected`.
- R7: Code 0x5 (data) while connected stores bits 7:0 of the incoming mailbox. Stored characters are read back in arrival order, and the ring wraps after 256 entries. When occupancy after the store is at most 252, the mailbox is cleared.
- R8: When occupancy after a store exceeds 252, the incoming mailbox is left holding its value and the block enters the held state.
- R9: In the held state, the pop that brings occupancy below 252 clears the incoming mailbox and leaves the held state.
- R10: A pop while `rd_avail` is 0 changes nothing.
- R11: `disc_req` sends code 0x3 on the outbound doorbell and clears `connected`. Data messages received while not connected are acknowledged, but nothing is stored and the mailbox is not cleared.
- R12: The outbound doorbell carries one code per cycle. When several codes are due at once, the ping reply goes first, then disconnect, then data, and the ones waiting are sent in later cycles.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| tx_valid | input | 1 | Local character offered |
| tx_char | input | 8 | Local character |
| tx_ready | output | 1 | Transmit engine can take a character |
| rd_avail | output | 1 | Ring holds at least one character |
| rd_data | output | 8 | Oldest character in the ring |
| rd_pop | input | 1 | Consume the oldest character |
| disc_req | input | 1 | Local request to close the session |
| connected | output | 1 | Session open |
| host_rx_wr | input | 1 | Host writes the incoming mailbox |
| host_rx_data | input | 32 | Value for the incoming mailbox |
| rx_mbox | output | 32 | Incoming mailbox contents |
| tx_mbox | output | 32 | Outgoing mailbox contents |
| host_tx_clr | input | 1 | Host empties the outgoing mailbox |
| host_db_wr | input | 1 | Host rings the inbound doorbell |
| host_db_code | input | 32 | Inbound doorbell code |
| in_db_ack | output | 1 | Inbound message handled (one-cycle pulse) |
| out_db_valid | output | 1 | Outbound doorbell rung this cycle |
| out_db_code | output | 32 | Outbound doorbell code |

## Verification
The occupancy and held-state checks assume that the host writes the incoming mailbox only while it reads zero. They also assume that the host rings the doorbell only after the previous message has been acknowledged. Without both, the ring could overfill and a doorbell could be lost. The stimulus keeps to both rules: every host write first polls `rx_mbox` for zero, every doorbell waits for `in_db_ack`, and the outgoing mailbox is cleared only once the character in it has been checked. The arbitration case deliberately makes a ping, a disconnect and a pending character fall due in the same cycle.

// File: rtl/mcon_pkg.sv
package mcon_pkg;

   typedef enum logic [2:0] {
      MSG_NONE,
      MSG_ALIVE,
      MSG_CONNECT,
      MSG_DATA,
      MSG_OTHER
   } msg_e;

   localparam logic [7:0] CODE_ALIVE   = 8'h01;
   localparam logic [7:0] CODE_CONNECT = 8'h02;
   localparam logic [7:0] CODE_DISC    = 8'h03;
   localparam logic [7:0] CODE_DATA    = 8'h05;

   localparam logic [7:0] CH_NL = 8'h0A;
   localparam logic [7:0] CH_CR = 8'h0D;

endpackage

// File: rtl/mcon_db_decode.sv
module mcon_db_decode
   import mcon_pkg::*;
#(
   parameter int DATA_W = 32
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              host_db_wr,
   input  logic [DATA_W-1:0] host_db_code,
   output msg_e              msg,
   output logic              ack
);

   logic              pend_v;
   logic [DATA_W-1:0] pend_code;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pend_v    <= 1'b0;
         pend_code <= '0;
         ack       <= 1'b0;
      end else begin
         ack <= pend_v;
         if (pend_v) begin
            pend_v <= 1'b0;
         end else if (host_db_wr) begin
            pend_v    <= 1'b1;
            pend_code <= host_db_code;
         end
      end
   end

   always_comb begin
      if (!pend_v)                                    msg = MSG_NONE;
      else if (pend_code == DATA_W'(CODE_ALIVE))      msg = MSG_ALIVE;
      else if (pend_code == DATA_W'(CODE_CONNECT))    msg = MSG_CONNECT;
      else if (pend_code == DATA_W'(CODE_DATA))       msg = MSG_DATA;
      else                                            msg = MSG_OTHER;
   end

   // R4
   ack_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      pend_v |=> (ack && !pend_v));

endmodule

// File: rtl/mcon_rx_ring.sv
module mcon_rx_ring #(
   parameter int DEPTH    = 256,
   parameter int HEADROOM = 4,
   parameter int CHAR_W   = 8
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              clr,
   input  logic              wr,
   input  logic [CHAR_W-1:0] wdata,
   input  logic              pop,
   output logic              avail,
   output logic [CHAR_W-1:0] rdata,
   output logic              mbox_clr
);

   localparam int PTR_W = $clog2(DEPTH);
   localparam int CNT_W = PTR_W + 1;
   localparam logic [CNT_W-1:0] LIMIT = CNT_W'(DEPTH - HEADROOM);

   initial begin
      depth_pow2_chk: assert (DEPTH >= 8 && (DEPTH & (DEPTH - 1)) == 0)
         else $error("ring depth must be a power of two of at least 8");
      headroom_chk: assert (HEADROOM >= 1 && HEADROOM < DEPTH / 2)
         else $error("headroom out of range");
   end

   logic [CHAR_W-1:0] mem [DEPTH];
   logic [PTR_W-1:0]  wptr_q, rptr_q;
   logic [CNT_W-1:0]  cnt_q, cnt_n;
   logic              held_q;
   logic              pop_ok;

   assign avail  = (cnt_q != '0);
   assign rdata  = mem[rptr_q];
   assign pop_ok = pop && avail;
   assign cnt_n  = cnt_q + CNT_W'(wr) - CNT_W'(pop_ok);

   always_comb begin
      mbox_clr = 1'b0;
      if (!clr) begin
         if (wr)
            mbox_clr = !(cnt_n > LIMIT);
         else if (pop_ok && held_q && cnt_n < LIMIT)
            mbox_clr = 1'b1;
      end
   end

   always_ff @(posedge clk) begin
      if (wr && !clr)
         mem[wptr_q] <= wdata;
   end

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
         held_q <= 1'b0;
      end else if (clr) begin
         wptr_q <= '0;
         rptr_q <= '0;
         cnt_q  <= '0;
         held_q <= 1'b0;
      end else begin
         if (wr)     wptr_q <= wptr_q + 1'b1;
         if (pop_ok) rptr_q <= rptr_q + 1'b1;
         cnt_q <= cnt_n;
         if (wr && cnt_n > LIMIT)
            held_q <= 1'b1;
         else if (!wr && pop_ok && held_q && cnt_n < LIMIT)
            held_q <= 1'b0;
      end
   end

   // R7
   no_overflow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      cnt_q <= CNT_W'(DEPTH));

   // R8
   held_level_chk: assert property (@(posedge clk) disable iff (!rst_n)
      held_q |-> (cnt_q >= LIMIT));

   // R10
   pop_empty_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (pop && !avail && !wr && !clr) |=> ($stable(rptr_q) && !avail));

endmodule

// File: rtl/mcon_tx_engine.sv
module mcon_tx_engine
   import mcon_pkg::*;
#(
   parameter int CHAR_W    = 8,
   parameter bit NL_EXPAND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [CHAR_W-1:0] tx_char,
   output logic              tx_ready,
   input  logic              mbox_free,
   input  logic              sent,
   output logic              send_req,
   output logic [CHAR_W-1:0] send_char
);

   initial begin
      char_w_chk: assert (CHAR_W >= 8)
         else $error("character width below 8 cannot carry line codes");
   end

   logic              hold_v;
   logic [CHAR_W-1:0] hold_q;
   logic              follow;

   generate
      if (NL_EXPAND) begin : g_nl_expand
         assign follow = (hold_q == CHAR_W'(CH_NL));
      end else begin : g_nl_plain
         assign follow = 1'b0;
      end
   endgenerate

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         hold_v <= 1'b0;
         hold_q <= '0;
      end else if (sent) begin
         if (follow) hold_q <= CHAR_W'(CH_CR);
         else        hold_v <= 1'b0;
      end else if (tx_valid && !hold_v) begin
         hold_v <= 1'b1;
         hold_q <= tx_char;
      end
   end

   assign tx_ready  = !hold_v;
   assign send_req  = hold_v && mbox_free;
   assign send_char = hold_q;

   // R3
   cr_follow_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (sent && follow) |=> (!tx_ready && send_char == CHAR_W'(CH_CR)));

endmodule

// File: rtl/mcon_endpoint.sv
module mcon_endpoint
   import mcon_pkg::*;
#(
   parameter int DATA_W    = 32,
   parameter int CHAR_W    = 8,
   parameter int DEPTH     = 256,
   parameter int HEADROOM  = 4,
   parameter bit NL_EXPAND = 1'b1
) (
   input  logic              clk,
   input  logic              rst_n,
   input  logic              tx_valid,
   input  logic [CHAR_W-1:0] tx_char,
   output logic              tx_ready,
   output logic              rd_avail,
   output logic [CHAR_W-1:0] rd_data,
   input  logic              rd_pop,
   input  logic              disc_req,
   output logic              connected,
   input  logic              host_rx_wr,
   input  logic [DATA_W-1:0] host_rx_data,
   output logic [DATA_W-1:0] rx_mbox,
   output logic [DATA_W-1:0] tx_mbox,
   input  logic              host_tx_clr,
   input  logic              host_db_wr,
   input  logic [DATA_W-1:0] host_db_code,
   output logic              in_db_ack,
   output logic              out_db_valid,
   output logic [DATA_W-1:0] out_db_code
);

   localparam int PAD_W = DATA_W - 1 - CHAR_W;

   initial begin
      data_w_chk: assert (DATA_W >= CHAR_W + 2)
         else $error("mailbox too narrow for flag and character");
   end

   msg_e              msg;
   logic              alive_go, disc_go, tx_go, conn_go, store;
   logic              disc_pend, conn_q;
   logic              send_req, mbox_clr;
   logic [CHAR_W-1:0] send_char;
   logic [DATA_W-1:0] rx_mbox_q, tx_mbox_q;

   mcon_db_decode #(.DATA_W(DATA_W)) u_decode (
      .clk          (clk),
      .rst_n        (rst_n),
      .host_db_wr   (host_db_wr),
      .host_db_code (host_db_code),
      .msg          (msg),
      .ack          (in_db_ack)
   );

   assign alive_go = (msg == MSG_ALIVE);
   assign conn_go  = (msg == MSG_CONNECT);
   assign store    = (msg == MSG_DATA) && conn_q;
   assign disc_go  = disc_pend && !alive_go;
   assign tx_go    = send_req && !alive_go && !disc_pend;

   mcon_rx_ring #(.DEPTH(DEPTH), .HEADROOM(HEADROOM), .CHAR_W(CHAR_W)) u_ring (
      .clk      (clk),
      .rst_n    (rst_n),
      .clr      (conn_go),
      .wr       (store),
      .wdata    (rx_mbox_q[CHAR_W-1:0]),
      .pop      (rd_pop),
      .avail    (rd_avail),
      .rdata    (rd_data),
      .mbox_clr (mbox_clr)
   );

   mcon_tx_engine #(.CHAR_W(CHAR_W), .NL_EXPAND(NL_EXPAND)) u_tx (
      .clk       (clk),
      .rst_n     (rst_n),
      .tx_valid  (tx_valid),
      .tx_char   (tx_char),
      .tx_ready  (tx_ready),
      .mbox_free (tx_mbox_q == '0),
      .sent      (tx_go),
      .send_req  (send_req),
      .send_char (send_char)
   );

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         disc_pend    <= 1'b0;
         conn_q       <= 1'b0;
         rx_mbox_q    <= '0;
         tx_mbox_q    <= '0;
         out_db_valid <= 1'b0;
         out_db_code  <= '0;
      end else begin
         if (disc_req)     disc_pend <= 1'b1;
         else if (disc_go) disc_pend <= 1'b0;

         if (conn_go)      conn_q <= 1'b1;
         else if (disc_go) conn_q <= 1'b0;

         if (host_rx_wr)                rx_mbox_q <= host_rx_data;
         else if (conn_go || mbox_clr)  rx_mbox_q <= '0;

         if (tx_go)            tx_mbox_q <= {1'b1, {PAD_W{1'b0}}, send_char};
         else if (host_tx_clr) tx_mbox_q <= '0;

         out_db_valid <= alive_go || disc_go || tx_go;
         if (alive_go)     out_db_code <= DATA_W'(CODE_ALIVE);
         else if (disc_go) out_db_code <= DATA_W'(CODE_DISC);
         else if (tx_go)   out_db_code <= DATA_W'(CODE_DATA);
         else              out_db_code <= '0;
      end
   end

   assign connected = conn_q;
   assign rx_mbox   = rx_mbox_q;
   assign tx_mbox   = tx_mbox_q;

   // R12
   db_single_chk: assert property (@(posedge clk) disable iff (!rst_n)
      $onehot0({alive_go, disc_go, tx_go}));

   // R2
   tx_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (tx_mbox_q != '0 && !host_tx_clr) |=> $stable(tx_mbox_q));

   // R5
   alive_reply_chk: assert property (@(posedge clk) disable iff (!rst_n)
      alive_go |=> (out_db_valid && out_db_code == DATA_W'(CODE_ALIVE)));

   // R6
   conn_clear_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (conn_go && !host_rx_wr) |=> (connected && !rd_avail && rx_mbox_q == '0));

   // R11
   disc_drop_chk: assert property (@(posedge clk) disable iff (!rst_n)
      (disc_go && !conn_go) |=> (!connected && out_db_code == DATA_W'(CODE_DISC)));

endmodule

// File: tb/mcon_endpoint_tb.sv
`timescale 1ns/1ps
module mcon_endpoint_tb;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        tx_valid = 1'b0;
   logic [7:0]  tx_char = '0;
   logic        tx_ready;
   logic        rd_avail;
   logic [7:0]  rd_data;
   logic        rd_pop = 1'b0;
   logic        disc_req = 1'b0;
   logic        connected;
   logic        host_rx_wr = 1'b0;
   logic [31:0] host_rx_data = '0;
   logic [31:0] rx_mbox, tx_mbox;
   logic        host_tx_clr = 1'b0;
   logic        host_db_wr = 1'b0;
   logic [31:0] host_db_code = '0;
   logic        in_db_ack;
   logic        out_db_valid;
   logic [31:0] out_db_code;

   int checks = 0;
   int fails  = 0;
   int evt_cnt = 0;
   bit done = 1'b0;

   logic [31:0] exp_db[$];
   logic [31:0] exp_tx[$];
   logic [7:0]  exp_rx[$];

   always #5 clk = ~clk;

   mcon_endpoint u_dut (
      .clk(clk), .rst_n(rst_n), .tx_valid(tx_valid), .tx_char(tx_char),
      .tx_ready(tx_ready), .rd_avail(rd_avail), .rd_data(rd_data),
      .rd_pop(rd_pop), .disc_req(disc_req), .connected(connected),
      .host_rx_wr(host_rx_wr), .host_rx_data(host_rx_data), .rx_mbox(rx_mbox),
      .tx_mbox(tx_mbox), .host_tx_clr(host_tx_clr), .host_db_wr(host_db_wr),
      .host_db_code(host_db_code), .in_db_ack(in_db_ack),
      .out_db_valid(out_db_valid), .out_db_code(out_db_code)
   );

   task automatic chk(input bit ok, input string req, input logic [31:0] act,
                      input logic [31:0] exp);
      checks++;
      if (!ok) begin
         fails++;
         $display("FAIL %s actual=%h expected=%h", req, act, exp);
      end
   endtask

   // monitor: every outbound doorbell is matched against the scoreboard
   always @(negedge clk) begin
      if (rst_n && out_db_valid) begin
         logic [31:0] e;
         evt_cnt++;
         if (exp_db.size() == 0) begin
            chk(1'b0, "R12 unexpected doorbell", out_db_code, 32'h0);
         end else begin
            e = exp_db.pop_front();
            chk(out_db_code == e, "R12 doorbell order", out_db_code, e);
            if (e == 32'h5) begin
               logic [31:0] t;
               t = (exp_tx.size() != 0) ? exp_tx.pop_front() : 32'hx;
               chk(tx_mbox == t, "R2 mailbox with data doorbell", tx_mbox, t);
            end
         end
      end
   end

   task automatic wait_ack();
      bit seen = 1'b0;
      for (int k = 0; k < 8; k++) begin
         @(negedge clk);
         if (in_db_ack) begin seen = 1'b1; break; end
      end
      chk(seen, "R4 doorbell acknowledged", {31'h0, seen}, 32'h1);
   endtask

   task automatic host_msg(input logic [31:0] code);
      @(negedge clk);
      host_db_wr = 1'b1; host_db_code = code;
      @(negedge clk);
      host_db_wr = 1'b0;
      wait_ack();
   endtask

   task automatic host_send(input logic [7:0] c, input bit keep);
      int n = 0;
      @(negedge clk);
      while (rx_mbox != 32'h0 && n < 50) begin @(negedge clk); n++; end
      if (n >= 50) chk(1'b0, "R7 mailbox never freed", rx_mbox, 32'h0);
      host_rx_wr = 1'b1; host_rx_data = 32'h8000_5500 | {24'h0, c};
      host_db_wr = 1'b1; host_db_code = 32'h5;
      if (keep) exp_rx.push_back(c);
      @(negedge clk);
      host_rx_wr = 1'b0; host_db_wr = 1'b0;
      wait_ack();
   endtask

   task automatic pop_check();
      logic [7:0] e;
      @(negedge clk);
      if (!rd_avail) begin
         chk(1'b0, "R7 data expected but ring empty", 32'h0, 32'h1);
      end else begin
         e = (exp_rx.size() != 0) ? exp_rx.pop_front() : 8'hxx;
         chk(rd_data == e, "R7 read order", {24'h0, rd_data}, {24'h0, e});
         rd_pop = 1'b1;
         @(negedge clk);
         rd_pop = 1'b0;
      end
   endtask

   task automatic send_tx(input logic [7:0] c);
      @(negedge clk);
      while (!tx_ready) @(negedge clk);
      tx_valid = 1'b1; tx_char = c;
      @(negedge clk);
      tx_valid = 1'b0;
   endtask

   task automatic host_take();
      @(negedge clk);
      host_tx_clr = 1'b1;
      @(negedge clk);
      host_tx_clr = 1'b0;
   endtask

   task automatic idle(input int n);
      repeat (n) @(negedge clk);
   endtask

   task automatic finish_run();
      done = 1'b1;
      $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
      $finish;
   endtask

   initial begin
      #2_000_000;
      if (!done) begin
         chk(1'b0, "watchdog expired", 32'h0, 32'h1);
         finish_run();
      end
   end

   initial begin
      int base;
      idle(3);
      // R1 reset state
      chk(!connected && !rd_avail && tx_ready && !out_db_valid && rx_mbox == 0 && tx_mbox == 0,
          "R1 reset state", {connected, rd_avail, tx_ready, out_db_valid}, 32'h2);
      rst_n = 1'b1;
      idle(2);

      // R11 data while disconnected is acked but ignored
      host_send(8'h41, 1'b0);
      idle(2);
      chk(rx_mbox == 32'h8000_5541, "R11 mailbox kept while disconnected", rx_mbox, 32'h8000_5541);
      chk(!rd_avail, "R11 nothing stored while disconnected", {31'h0, rd_avail}, 32'h0);

      // R6 connect
      host_msg(32'h2);
      chk(connected, "R6 connected set", {31'h0, connected}, 32'h1);
      chk(rx_mbox == 0, "R6 mailbox cleared", rx_mbox, 32'h0);
      chk(!rd_avail, "R6 ring empty", {31'h0, rd_avail}, 32'h0);

      // R10 pop on empty
      @(negedge clk); rd_pop = 1'b1;
      @(negedge clk); rd_pop = 1'b0;
      chk(!rd_avail, "R10 pop on empty", {31'h0, rd_avail}, 32'h0);
      host_send(8'h5A, 1'b1);
      pop_check();

      // R7 several characters, mailbox cleared after each
      for (int i = 0; i < 5; i++) begin
         host_send(8'h30 + 8'(i), 1'b1);
         chk(rx_mbox == 0, "R7 mailbox cleared after store", rx_mbox, 32'h0);
      end
      for (int i = 0; i < 5; i++) pop_check();

      // R5 ping
      exp_db.push_back(32'h1);
      base = evt_cnt;
      host_msg(32'h1);
      idle(2);
      chk(evt_cnt == base + 1, "R5 ping answered", evt_cnt, base + 1);

      // R4 unknown code
      host_send(8'h77, 1'b1);
      base = evt_cnt;
      host_msg(32'h7);
      idle(3);
      chk(evt_cnt == base, "R4 unknown code no doorbell", evt_cnt, base);
      chk(rd_avail && rx_mbox == 0, "R4 unknown code leaves state", {rd_avail, rx_mbox[30:0]}, 32'h8000_0000);
      pop_check();

      // R2 transmit and hold
      exp_db.push_back(32'h5); exp_tx.push_back(32'h8000_0041);
      send_tx(8'h41);
      idle(3);
      chk(tx_mbox == 32'h8000_0041, "R2 character in mailbox", tx_mbox, 32'h8000_0041);
      base = evt_cnt;
      send_tx(8'h42);
      idle(5);
      chk(evt_cnt == base && tx_mbox == 32'h8000_0041, "R2 held while mailbox busy", tx_mbox, 32'h8000_0041);
      exp_db.push_back(32'h5); exp_tx.push_back(32'h8000_0042);
      host_take();
      idle(3);
      chk(tx_mbox == 32'h8000_0042, "R2 next after clear", tx_mbox, 32'h8000_0042);
      host_take();

      // R3 newline expansion
      exp_db.push_back(32'h5); exp_tx.push_back(32'h8000_000A);
      send_tx(8'h0A);
      idle(3);
      chk(!tx_ready, "R3 busy until return sent", {31'h0, tx_ready}, 32'h0);
      exp_db.push_back(32'h5); exp_tx.push_back(32'h8000_000D);
      host_take();
      idle(3);
      chk(tx_mbox == 32'h8000_000D && tx_ready, "R3 return follows newline", tx_mbox, 32'h8000_000D);
      host_take();

      // R8 and R9 flow control
      for (int i = 0; i < 253; i++) host_send(8'(i), 1'b1);
      idle(4);
      chk(rx_mbox == 32'h8000_55FC, "R8 mailbox held above threshold", rx_mbox, 32'h8000_55FC);
      pop_check();
      idle(2);
      chk(rx_mbox == 32'h8000_55FC, "R9 still held at 252", rx_mbox, 32'h8000_55FC);
      pop_check();
      idle(2);
      chk(rx_mbox == 0, "R9 mailbox cleared below 252", rx_mbox, 32'h0);
      while (rd_avail) pop_check();
      chk(exp_rx.size() == 0, "R7 all characters drained", exp_rx.size(), 32'h0);

      // R7 continue across wrap
      for (int i = 0; i < 10; i++) host_send(8'hC0 + 8'(i), 1'b1);
      for (int i = 0; i < 10; i++) pop_check();
      chk(!rd_avail, "R7 empty after wrap", {31'h0, rd_avail}, 32'h0);

      // R12 arbitration with R11 disconnect
      exp_db.push_back(32'h1); exp_db.push_back(32'h3);
      exp_db.push_back(32'h5); exp_tx.push_back(32'h8000_0051);
      base = evt_cnt;
      @(negedge clk);
      tx_valid = 1'b1; tx_char = 8'h51; disc_req = 1'b1;
      host_db_wr = 1'b1; host_db_code = 32'h1;
      @(negedge clk);
      tx_valid = 1'b0; disc_req = 1'b0; host_db_wr = 1'b0;
      idle(6);
      chk(evt_cnt == base + 3, "R12 three doorbells", evt_cnt, base + 3);
      chk(!connected, "R11 disconnect clears connected", {31'h0, connected}, 32'h0);
      host_take();

      host_msg(32'h2);
      chk(connected, "R6 reconnect", {31'h0, connected}, 32'h1);
      idle(3);
      chk(exp_db.size() == 0, "R12 all expected doorbells seen", exp_db.size(), 32'h0);
      finish_run();
   end

endmodule